// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sets the reduced-power state of a small 8-bit microcontroller core. Software writes a power-control register over a simple register bus. One bit requests an idle state and another requests a power-down state. The block turns that state into clock enables and peripheral enables for the rest of the chip. It also divides the incoming oscillator clock by two to make the internal clock. The divider is a toggle flop, so the duty cycle of the input clock does not matter. Every enable it produces qualifies a single internal tick, which is high on one input cycle out of two.

In idle, the CPU clock enable is held low. The timers and the interrupt logic keep their enable pulses. The A/D converter and PWM enables drop. Any interrupt that is both pending and enabled ends idle, so the CPU can service that interrupt. Power-down removes the oscillator enable, and with it every clock. Interrupts cannot end power-down; only a hardware reset does. After reset release, and again after every exit from idle, an A/D ready flag stays low until a fixed number of internal ticks has passed. This gives the analog reference time to settle before a conversion is started.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While reset is held and right after its release, the power-control register reads 0. In that state the oscillator, A/D and PWM enables are 1, the ready flag is 0, and the internal clock and the CPU enable are 0.
- R2: While the oscillator runs, the internal clock inverts on every input clock cycle. The CPU enable (in run) and the peripheral enable equal the internal clock's high phase, so each is high on exactly one cycle in two.
- R3: A write of bit 0 = 1 and bit 1 = 0 to the power-control address enters idle on the next clock. In idle, bit 0 reads 1, the CPU enable stays 0, the peripheral enable keeps pulsing, and the A/D and PWM enables are 0.
- R4: A write with bit 1 = 1 enters power-down, whatever bit 0 holds. The oscillator enable and all other enables go to 0, and the internal clock holds its level.
- R5: In idle, any interrupt line with both its pending and enable bits at 1 returns the block to run at the next clock. Bit 0 then reads 0.
- R6: In idle, pending interrupts whose enable bit is 0 do not end idle.
- R7: Power-down ignores all interrupts, and only reset leaves it.
- R8: Register writes are ignored in idle and in power-down. Writes to any other address are also ignored.
- R9: The ready flag rises only after exactly SETTLE_TICKS internal ticks in run have passed since reset release or since an idle exit. It is 0 whenever the block is not in run.
- R10: A read at the power-control address returns bit 1 = power-down and bit 0 = idle, with the upper bits 0. A read at any other address returns 0. Data bits 7..2 of a write have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low hardware reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |
| irqPending | input | IRQ_N | Interrupt pending lines |
| irqEnable | input | IRQ_N | Interrupt enable lines |
| intClk | output | 1 | Internal clock (input divided by two) |
| oscEn | output | 1 | Oscillator enable |
| cpuClkEn | output | 1 | CPU clock enable tick |
| periphClkEn | output | 1 | Timer and interrupt logic clock enable tick |
| adcEn | output | 1 | A/D converter enable |
| pwmEn | output | 1 | PWM enable |
| adcReady | output | 1 | A/D reference settled; conversions may start |

## Verification
The hardest state to reach from the ports is the set of idle wake decisions: each combination of pending and enable lines must be tried from a fresh idle entry. A matching, enabled interrupt is then needed to recover whenever the combination should not wake the block. The bench sweeps all 256 pending/enable pairs of a four-line configuration. Each pass re-enters idle through a register write and computes the expected wake from the AND of the two vectors. The settle window is timed by counting CPU enable ticks from reset release and from selected idle exits. Power-down is reached with both write codes that set bit 1, and reset is the only way out.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int PconIdlBit = 0;
  localparam int PconPdBit  = 1;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_DOWN = 2'd2
  } pmMode_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadReg;
    logic idlBit;
    logic pdBit;
    logic clearIdl;
    logic settleRestart;
    logic runActive;
    logic oscActive;
  } pmStrobe_t;

endpackage

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] PCON_ADDR = 4'h7,
  parameter int IRQ_N = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wdIdl,
  input  logic              wdPd,
  input  logic [IRQ_N-1:0]  irqPending,
  input  logic [IRQ_N-1:0]  irqEnable,
  output pmMode_t           mode,
  output pmStrobe_t         strb
);

  pmMode_t modeNext;
  logic [IRQ_N-1:0] irqLive;
  logic wakeReq;
  logic writeHit;

  // per-line qualification of interrupt requests
  for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
    assign irqLive[i] = irqPending[i] & irqEnable[i];
  end

  assign wakeReq  = |irqLive;
  assign writeHit = busWe && (busAddr == PCON_ADDR) && (mode == MODE_RUN);

  always_comb begin
    modeNext           = mode;
    strb               = '0;
    strb.runActive     = (mode == MODE_RUN);
    strb.oscActive     = (mode != MODE_DOWN);
    strb.idlBit        = wdIdl;
    strb.pdBit         = wdPd;
    unique case (mode)
      MODE_RUN: begin
        if (writeHit) begin
          strb.loadReg = 1'b1;
          if (wdPd)       modeNext = MODE_DOWN;
          else if (wdIdl) modeNext = MODE_IDLE;
        end
      end
      MODE_IDLE: begin
        if (wakeReq) begin
          modeNext           = MODE_RUN;
          strb.clearIdl      = 1'b1;
          strb.settleRestart = 1'b1;
        end
      end
      MODE_DOWN: modeNext = MODE_DOWN;
      default:   modeNext = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_RUN;
    else       mode <= modeNext;
  end

  assert_wake_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_IDLE && wakeReq) |=> (mode == MODE_RUN));

  // R6 and R8: no wake request and no write can move idle
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_IDLE && !wakeReq) |=> (mode == MODE_IDLE));

  assert_down_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_DOWN) |=> (mode == MODE_DOWN));

  assert_pd_priority_R4: assert property (@(posedge clk) disable iff (!rstN)
    (writeHit && wdPd) |=> (mode == MODE_DOWN));

endmodule

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int SETTLE_TICKS = 256
) (
  input  logic      clk,
  input  logic      rstN,
  input  pmStrobe_t strb,
  output logic      idlQ,
  output logic      pdQ,
  output logic      intClk,
  output logic      tick,
  output logic      adcReady
);

  localparam int CNT_W = $clog2(SETTLE_TICKS + 1);
  localparam logic [CNT_W-1:0] SettleEnd = CNT_W'(SETTLE_TICKS);

  logic divQ;
  logic [CNT_W-1:0] settleCnt;
  logic settleDone;

  // divide-by-two toggle flop, frozen while the oscillator is off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               divQ <= 1'b0;
    else if (strb.oscActive) divQ <= ~divQ;
  end

  assign intClk = divQ;
  assign tick   = divQ;

  // power-control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idlQ <= 1'b0;
      pdQ  <= 1'b0;
    end else if (strb.loadReg) begin
      idlQ <= strb.idlBit;
      pdQ  <= strb.pdBit;
    end else if (strb.clearIdl) begin
      idlQ <= 1'b0;
    end
  end

  // analog reference settle counter, in internal ticks
  assign settleDone = (settleCnt == SettleEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       settleCnt <= '0;
    else if (strb.settleRestart)                     settleCnt <= '0;
    else if (strb.runActive && tick && !settleDone)  settleCnt <= settleCnt + 1'b1;
  end

  assign adcReady = settleDone && strb.runActive;

  assert_div_toggle_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.oscActive |=> (intClk != $past(intClk)));

  assert_settle_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.settleRestart |=> !adcReady);

  assert_idl_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearIdl |=> !idlQ);

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] PCON_ADDR = 4'h7,
  parameter int IRQ_N = 4,
  parameter int SETTLE_TICKS = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic [IRQ_N-1:0]  irqPending,
  input  logic [IRQ_N-1:0]  irqEnable,
  output logic              intClk,
  output logic              oscEn,
  output logic              cpuClkEn,
  output logic              periphClkEn,
  output logic              adcEn,
  output logic              pwmEn,
  output logic              adcReady
);

  pmMode_t   mode;
  pmStrobe_t strb;
  logic idlQ, pdQ, tick;

  pwr_mode_ctrl #(
    .ADDR_W(ADDR_W), .PCON_ADDR(PCON_ADDR), .IRQ_N(IRQ_N)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .wdIdl(busWdata[PconIdlBit]), .wdPd(busWdata[PconPdBit]),
    .irqPending(irqPending), .irqEnable(irqEnable),
    .mode(mode), .strb(strb)
  );

  pwr_mode_dp #(
    .SETTLE_TICKS(SETTLE_TICKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .idlQ(idlQ), .pdQ(pdQ), .intClk(intClk), .tick(tick), .adcReady(adcReady)
  );

  always_comb begin
    busRdata = '0;
    if (busAddr == PCON_ADDR) begin
      busRdata[PconIdlBit] = idlQ;
      busRdata[PconPdBit]  = pdQ;
    end
  end

  assign oscEn       = strb.oscActive;
  assign cpuClkEn    = tick && strb.runActive;
  assign periphClkEn = tick && strb.oscActive;
  assign adcEn       = strb.runActive;
  assign pwmEn       = strb.runActive;

  assert_cpu_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    idlQ |-> (!cpuClkEn && !adcEn && !pwmEn));

  assert_down_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    pdQ |-> (!oscEn && !periphClkEn && !cpuClkEn));

  assert_ready_in_run_R9: assert property (@(posedge clk) disable iff (!rstN)
    adcReady |-> adcEn);

endmodule

// File: tb/sim_pwr_mode_ctl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctl;

  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] PCON = 4'h7;
  localparam int IRQ_N = 4;
  localparam int SETTLE = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [ADDR_W-1:0] busAddr = PCON;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [IRQ_N-1:0] irqPending = '0;
  logic [IRQ_N-1:0] irqEnable = '0;
  logic intClk, oscEn, cpuClkEn, periphClkEn, adcEn, pwmEn, adcReady;

  int checks = 0;
  int errs = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctl #(
    .ADDR_W(ADDR_W), .PCON_ADDR(PCON), .IRQ_N(IRQ_N), .SETTLE_TICKS(SETTLE)
  ) u0 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .irqPending(irqPending), .irqEnable(irqEnable),
    .intClk(intClk), .oscEn(oscEn), .cpuClkEn(cpuClkEn),
    .periphClkEn(periphClkEn), .adcEn(adcEn), .pwmEn(pwmEn), .adcReady(adcReady)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeReg(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    busAddr = a;
    busWdata = d;
    busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    busAddr = PCON;
  endtask

  task automatic countSettle(output int n);
    n = 0;
    while (!adcReady && n < 1000) begin
      if (cpuClkEn) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n;
    logic lastClk;
    int hi;

    // R1 during reset and right after release
    @(negedge clk);
    check("R1 reg in reset", busRdata, 0);
    check("R1 ready in reset", adcReady, 0);
    doReset();
    check("R1 reg", busRdata, 0);
    check("R1 oscEn", oscEn, 1);
    check("R1 adcEn", adcEn, 1);
    check("R1 pwmEn", pwmEn, 1);
    check("R1 adcReady", adcReady, 0);
    check("R1 intClk", intClk, 0);
    check("R1 cpuClkEn", cpuClkEn, 0);

    // R9 settle window after reset release
    countSettle(n);
    check("R9 ticks after reset", n, SETTLE);
    repeat (3) @(negedge clk);
    check("R9 ready holds", adcReady, 1);

    // R2 divider and tick qualification
    lastClk = intClk;
    hi = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R2 intClk toggles", intClk, !lastClk);
      check("R2 cpu tick = high phase", cpuClkEn, intClk);
      check("R2 periph tick = high phase", periphClkEn, intClk);
      hi += cpuClkEn;
      lastClk = intClk;
    end
    check("R2 one in two", hi, 4);

    // R8 write to other address ignored; R10 read elsewhere is 0
    writeReg(PCON ^ 4'h1, 8'h03);
    check("R8 other address", busRdata, 0);
    check("R8 still running", oscEn && adcEn, 1);
    busAddr = PCON ^ 4'h1;
    check("R10 other read", busRdata, 0);
    busAddr = PCON;

    // R10 upper data bits ignored
    writeReg(PCON, 8'hFC);
    check("R10 upper bits", busRdata, 0);
    check("R10 stays run", adcEn, 1);

    // R3 R5 R6 R8 idle sweep over all pending/enable pairs
    for (int p = 0; p < 16; p++) begin
      for (int e = 0; e < 16; e++) begin
        int cpuHi;
        int perHi;
        bit woke;
        writeReg(PCON, 8'h01);
        check("R3 idle reads 1", busRdata, 1);
        check("R3 adcEn off", adcEn, 0);
        check("R3 pwmEn off", pwmEn, 0);
        check("R9 ready off in idle", adcReady, 0);
        cpuHi = 0;
        perHi = 0;
        for (int k = 0; k < 2; k++) begin
          cpuHi += cpuClkEn;
          perHi += periphClkEn;
          @(negedge clk);
        end
        check("R3 cpu gated", cpuHi, 0);
        check("R3 periph runs", perHi, 1);
        if (p == 0 && e == 0) begin
          writeReg(PCON, 8'h02);
          check("R8 write in idle", busRdata, 1);
          check("R8 osc kept", oscEn, 1);
        end
        irqPending = IRQ_N'(p);
        irqEnable = IRQ_N'(e);
        @(negedge clk);
        woke = (p & e) != 0;
        if (woke) check("R5 wake", busRdata, 0);
        else      check("R6 no wake", busRdata, 1);
        irqPending = '0;
        irqEnable = '0;
        if (!woke) begin
          irqPending = 4'b0001;
          irqEnable = 4'b0001;
          @(negedge clk);
          irqPending = '0;
          irqEnable = '0;
          check("R5 recover wake", busRdata, 0);
        end
        check("R5 adcEn back", adcEn, 1);
        if (e == 15 && (p == 1 || p == 8)) begin
          countSettle(n);
          check("R9 ticks after idle exit", n, SETTLE);
        end
      end
    end

    // R4 R7 R8 power-down with both codes that set bit 1
    for (int d = 2; d < 4; d++) begin
      logic heldClk;
      doReset();
      writeReg(PCON, 8'(d));
      check("R4 reads code", busRdata, d);
      check("R4 oscEn off", oscEn, 0);
      check("R4 adcEn off", adcEn, 0);
      check("R4 pwmEn off", pwmEn, 0);
      heldClk = intClk;
      irqPending = '1;
      irqEnable = '1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        check("R4 intClk held", intClk, heldClk);
        check("R4 periph off", periphClkEn, 0);
        check("R4 cpu off", cpuClkEn, 0);
        check("R7 irq ignored", busRdata, d);
      end
      irqPending = '0;
      irqEnable = '0;
      writeReg(PCON, 8'h00);
      check("R8 write in power-down", busRdata, d);
      doReset();
      check("R7 reset exits", busRdata, 0);
      check("R7 osc back", oscEn, 1);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule